// File: doc/BRIEF.md
# Serial Flag Offset Loader

This block fills the two threshold registers that a FIFO's programmable flags compare against: the almost-empty offset and the almost-full offset. Both are loaded through a one-bit serial port clocked by `sclk`. A bit is taken on each rising `sclk` edge while the active-low `load_n` and `sen_n` are both low. The stream starts with the least significant bit of the almost-empty offset and ends with the most significant bit of the almost-full offset. Bits are collected in a staging register, and the visible offsets change only when the last bit of a complete set has arrived. The register width is the parameter `OFS_W` when the FIFO has a wide port. When both FIFO ports are narrow (`narrow_mode` = 1), each register is one bit wider.

Loading can be paused at any point by raising either `load_n` or `sen_n`. While it is paused, the surrounding FIFO can go on accepting writes. When both controls are low again, loading resumes with the next bit of the sequence. From the first accepted bit until the set is complete, both flag-valid outputs are held low. After completion, the almost-full valid rises on the third following `wclk` edge and the almost-empty valid on the third following `rclk` edge. Each release passes through a two-flop synchronizer and one output flop. A fresh complete sequence replaces both offsets at any time.

Top module: `flag_offset_serial_loader`

## Requirements
- R1: A serial bit is consumed only on a rising `sclk` edge with `load_n` = 0 and `sen_n` = 0. With `sen_n` = 1 or `load_n` = 1, the bit position does not advance and `sdata` is discarded.
- R2: Bit number k of a sequence (counting from 0) goes to `empty_ofs[k]` for k < W. Otherwise it goes to `full_ofs[k-W]`. W is `OFS_W` when `narrow_mode` = 0 and `OFS_W`+1 when `narrow_mode` = 1.
- R3: A complete sequence is 2·`OFS_W` bits when `narrow_mode` = 0 and 2·`OFS_W`+2 bits when `narrow_mode` = 1. With `narrow_mode` = 0, bit `OFS_W` of both offset outputs reads 0.
- R4: `empty_ofs` and `full_ofs` keep their previous values until the `sclk` edge that takes the last bit of a sequence. On that edge both update together.
- R5: The bit position wraps to 0 after the last bit, so the next sequence replaces both offsets in full.
- R6: A load paused by raising `sen_n` or `load_n` for any number of cycles resumes at the next bit in sequence and yields the same offsets as an uninterrupted load.
- R7: `af_valid` and `ae_valid` are 0 from the `sclk` edge that takes the first bit of a sequence until that sequence completes.
- R8: `af_valid` is still 0 after the second rising `wclk` edge following the completing `sclk` edge, and is 1 after the third.
- R9: `ae_valid` is still 0 after the second rising `rclk` edge following the completing `sclk` edge, and is 1 after the third.
- R10: While `rst_n` = 0, both offsets read 0 and both valid outputs read 0, immediately and without a clock. After reset, the next sequence starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial load clock |
| wclk | input | 1 | FIFO write-side clock |
| rclk | input | 1 | FIFO read-side clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| narrow_mode | input | 1 | 1 = both FIFO ports narrow (one extra offset bit per register) |
| load_n | input | 1 | Active-low load select |
| sen_n | input | 1 | Active-low serial enable |
| sdata | input | 1 | Serial offset data |
| empty_ofs | output | OFS_W+1 | Almost-empty offset |
| full_ofs | output | OFS_W+1 | Almost-full offset |
| af_valid | output | 1 | Almost-full flag valid, `wclk` domain |
| ae_valid | output | 1 | Almost-empty flag valid, `rclk` domain |

## Verification
The bench walks every offset pair a small configuration can hold, in both bus modes, and computes each expected register value from the bit order.

- **Pauses (R1, R6):** During some loads it inserts pauses with garbage on `sdata`. A design that shifted during a pause, or restarted after one, would load rotated or corrupted offsets.
- **Premature update (R4):** It checks that the outputs still hold the old pair just before the final bit. A design that wrote the registers bit by bit would show a half-updated pair.
- **Release timing (R7, R8, R9):** It counts `wclk` and `rclk` edges after completion, so a missing or extra synchronizer stage shows up as a release one edge early or late.
- **Reset mid-load (R10):** A reset in the middle of a load must clear the position, or the next load would land shifted.

// File: rtl/fol_pkg.sv
package fol_pkg;
  // Bus-width selection for the offset registers
  typedef enum logic {
    BUS_WIDE   = 1'b0,
    BUS_NARROW = 1'b1
  } bus_mode_e;

  // Synchronizer depth used by each flag release path
  localparam int unsigned FOL_SYNC_STAGES = 2;
endpackage

// File: rtl/fol_rst_sync.sv
module fol_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;
  logic [1:0] sync_nx;

  always_comb sync_nx = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_nx;
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/fol_shift_core.sv
module fol_shift_core #(
  parameter int unsigned OFS_W = 10
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             narrow_mode,
  input  logic             load_n,
  input  logic             sen_n,
  input  logic             sdata,
  output logic [OFS_W:0]   empty_ofs,
  output logic [OFS_W:0]   full_ofs,
  output logic             loading,
  output logic             loaded
);
  import fol_pkg::*;

  localparam int unsigned RW    = OFS_W + 1;
  localparam int unsigned STG_W = 2 * RW;
  localparam int unsigned CNT_W = $clog2(STG_W);

  bus_mode_e          mode;
  logic               shift_en;
  logic               complete;
  logic [CNT_W-1:0]   last_idx;
  logic [CNT_W-1:0]   half;
  logic [RW-1:0]      keep_mask;

  logic [CNT_W-1:0]   bit_cnt_q,  bit_cnt_nx;
  logic [RW-1:0]      e_stg_q,    e_stg_nx;
  logic [RW-1:0]      f_stg_q,    f_stg_nx;
  logic [RW-1:0]      e_ofs_q,    e_ofs_nx;
  logic [RW-1:0]      f_ofs_q,    f_ofs_nx;
  logic               busy_q,     busy_nx;
  logic               done_q,     done_nx;

  assign mode      = bus_mode_e'(narrow_mode);
  assign shift_en  = !load_n && !sen_n;
  assign last_idx  = (mode == BUS_NARROW) ? CNT_W'(STG_W - 1) : CNT_W'(2 * OFS_W - 1);
  assign half      = (mode == BUS_NARROW) ? CNT_W'(RW) : CNT_W'(OFS_W);
  assign keep_mask = (mode == BUS_NARROW) ? {RW{1'b1}} : {1'b0, {OFS_W{1'b1}}};
  assign complete  = shift_en && (bit_cnt_q == last_idx);

  // Next-state: bit position, staging, commit, status
  always_comb begin
    e_stg_nx   = e_stg_q;
    f_stg_nx   = f_stg_q;
    bit_cnt_nx = bit_cnt_q;
    busy_nx    = busy_q;
    done_nx    = done_q;
    if (shift_en) begin
      for (int i = 0; i < int'(RW); i++) begin
        if ((bit_cnt_q < half) && (bit_cnt_q == CNT_W'(i))) e_stg_nx[i] = sdata;
        if (bit_cnt_q == half + CNT_W'(i))                  f_stg_nx[i] = sdata;
      end
      bit_cnt_nx = complete ? '0 : bit_cnt_q + 1'b1;
      busy_nx    = !complete;
      done_nx    = complete;
    end
    e_ofs_nx = complete ? (e_stg_nx & keep_mask) : e_ofs_q;
    f_ofs_nx = complete ? (f_stg_nx & keep_mask) : f_ofs_q;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      e_stg_q   <= '0;
      f_stg_q   <= '0;
      e_ofs_q   <= '0;
      f_ofs_q   <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      bit_cnt_q <= bit_cnt_nx;
      e_stg_q   <= e_stg_nx;
      f_stg_q   <= f_stg_nx;
      e_ofs_q   <= e_ofs_nx;
      f_ofs_q   <= f_ofs_nx;
      busy_q    <= busy_nx;
      done_q    <= done_nx;
    end
  end

  assign empty_ofs = e_ofs_q;
  assign full_ofs  = f_ofs_q;
  assign loading   = busy_q;
  assign loaded    = done_q;

  // R1
  hold_no_shift_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (load_n || sen_n) |=> $stable(bit_cnt_q));
  // R4
  ofs_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !complete |=> ($stable(e_ofs_q) && $stable(f_ofs_q)));
  // R5
  cnt_range_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    bit_cnt_q <= last_idx);
  // R7
  busy_first_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (shift_en && bit_cnt_q == '0) |=> busy_q);
endmodule

// File: rtl/fol_flag_release.sv
module fol_flag_release #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loaded,
  input  logic loading,
  output logic valid
);
  logic [SYNC_STAGES-1:0] chain_q, chain_nx;
  logic                   rel_q,   rel_nx;

  always_comb begin
    chain_nx = {chain_q[SYNC_STAGES-2:0], loaded};
    rel_nx   = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      rel_q   <= 1'b0;
    end else begin
      chain_q <= chain_nx;
      rel_q   <= rel_nx;
    end
  end

  // Forced low as soon as a new sequence has begun
  assign valid = rel_q && !loading;

  // R8
  rise_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> $past(chain_q[SYNC_STAGES-1]));
endmodule

// File: rtl/flag_offset_serial_loader.sv
module flag_offset_serial_loader #(
  parameter int unsigned OFS_W       = 10,
  parameter int unsigned SYNC_STAGES = fol_pkg::FOL_SYNC_STAGES
) (
  input  logic           sclk,
  input  logic           wclk,
  input  logic           rclk,
  input  logic           rst_n,
  input  logic           narrow_mode,
  input  logic           load_n,
  input  logic           sen_n,
  input  logic           sdata,
  output logic [OFS_W:0] empty_ofs,
  output logic [OFS_W:0] full_ofs,
  output logic           af_valid,
  output logic           ae_valid
);
  logic srst_n, wrst_n, rrst_n;
  logic loading, loaded;

  fol_rst_sync u_srst (.clk(sclk), .rst_n(rst_n), .rst_sn(srst_n));
  fol_rst_sync u_wrst (.clk(wclk), .rst_n(rst_n), .rst_sn(wrst_n));
  fol_rst_sync u_rrst (.clk(rclk), .rst_n(rst_n), .rst_sn(rrst_n));

  fol_shift_core #(.OFS_W(OFS_W)) u_core (
    .sclk        (sclk),
    .rst_n       (srst_n),
    .narrow_mode (narrow_mode),
    .load_n      (load_n),
    .sen_n       (sen_n),
    .sdata       (sdata),
    .empty_ofs   (empty_ofs),
    .full_ofs    (full_ofs),
    .loading     (loading),
    .loaded      (loaded)
  );

  fol_flag_release #(.SYNC_STAGES(SYNC_STAGES)) u_af_rel (
    .clk     (wclk),
    .rst_n   (wrst_n),
    .loaded  (loaded),
    .loading (loading),
    .valid   (af_valid)
  );

  fol_flag_release #(.SYNC_STAGES(SYNC_STAGES)) u_ae_rel (
    .clk     (rclk),
    .rst_n   (rrst_n),
    .loaded  (loaded),
    .loading (loading),
    .valid   (ae_valid)
  );
endmodule

// File: tb/flag_offset_serial_loader_tb.sv
`timescale 1ns/100ps
module flag_offset_serial_loader_tb;
  localparam int W = 4;

  logic sclk = 1'b0, wclk = 1'b0, rclk = 1'b0;
  logic rst_n = 1'b0, narrow_mode = 1'b0, load_n = 1'b1, sen_n = 1'b1, sdata = 1'b0;
  logic [W:0] empty_ofs, full_ofs;
  logic af_valid, ae_valid;

  int n_chk = 0, n_fail = 0;
  logic [W:0] old_e = '0, old_f = '0;
  bit finished = 0;

  flag_offset_serial_loader #(.OFS_W(W)) u_dut (
    .sclk(sclk), .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .narrow_mode(narrow_mode), .load_n(load_n), .sen_n(sen_n), .sdata(sdata),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .af_valid(af_valid), .ae_valid(ae_valid)
  );

  always #4 sclk = ~sclk;                       // 125 MHz
  initial begin #1.5; forever #5 wclk = ~wclk; end
  initial begin #2.5; forever #7 rclk = ~rclk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_load(input bit nar, input int e, input int f, input bit pause);
    int L;
    bit b;
    L = nar ? W + 1 : W;
    for (int k = 0; k < 2 * L; k++) begin
      b = (k < L) ? (((e >> k) & 1) != 0) : (((f >> (k - L)) & 1) != 0);
      if (pause && k == 3) begin
        // R1 R6: sen_n high then load_n high, garbage data, no shift
        @(negedge sclk); load_n = 0; sen_n = 1; sdata = ~b;
        @(negedge sclk);
        @(negedge sclk); load_n = 1; sen_n = 0;
      end
      @(negedge sclk); load_n = 0; sen_n = 0; sdata = b;
      @(posedge sclk);
      if (k == 0) begin
        #1; chk(af_valid == 0 && ae_valid == 0, "R7", int'(af_valid) + int'(ae_valid), 0);
      end
      if (k == 2 * L - 2) begin
        #1; chk(empty_ofs == old_e && full_ofs == old_f, "R4", int'(empty_ofs), int'(old_e));
      end
    end
    fork
      begin @(negedge sclk); load_n = 1; sen_n = 1; end
      begin
        repeat (2) @(posedge wclk); #1 chk(af_valid == 0, "R8", af_valid, 0);
        @(posedge wclk); #1 chk(af_valid == 1, "R8", af_valid, 1);
      end
      begin
        repeat (2) @(posedge rclk); #1 chk(ae_valid == 0, "R9", ae_valid, 0);
        @(posedge rclk); #1 chk(ae_valid == 1, "R9", ae_valid, 1);
      end
    join
    // R2 R3: order and width; wide mode has a zero top bit
    chk(empty_ofs == (W + 1)'(e), "R2 empty", int'(empty_ofs), e);
    chk(full_ofs  == (W + 1)'(f), "R3 full",  int'(full_ofs),  f);
    old_e = (W + 1)'(e);
    old_f = (W + 1)'(f);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #3;
    // R10: reset state
    chk(empty_ofs == 0 && full_ofs == 0, "R10", int'(empty_ofs), 0);
    chk(af_valid == 0 && ae_valid == 0, "R10", int'(af_valid), 0);
    #20 rst_n = 1;
    repeat (4) @(posedge rclk);

    // Wide mode: every pair, pauses on some; each reload exercises R5
    for (int e = 0; e < (1 << W); e++)
      for (int f = 0; f < (1 << W); f++)
        do_load(1'b0, e, f, ((e ^ f) & 1) != 0);

    // R10: reset in mid-sequence clears outputs at once and restarts position
    @(negedge sclk); load_n = 0; sen_n = 0; sdata = 1;
    repeat (3) @(negedge sclk);
    load_n = 1; sen_n = 1;
    rst_n = 0; #1;
    chk(empty_ofs == 0 && full_ofs == 0, "R10", int'(full_ofs), 0);
    chk(af_valid == 0 && ae_valid == 0, "R10", int'(ae_valid), 0);
    old_e = '0; old_f = '0;
    narrow_mode = 1;
    #20 rst_n = 1;
    repeat (4) @(posedge rclk);
    do_load(1'b1, 5'h15, 5'h0A, 1'b0);  // R5 R10: position restarted at 0

    // Narrow mode: every pair
    for (int e = 0; e < (1 << (W + 1)); e++)
      for (int f = 0; f < (1 << (W + 1)); f++)
        do_load(1'b1, e, f, ((e + f) % 3) == 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule